// File: doc/BRIEF.md
# Rail Fault Supervisor with Health/Reset Output

This block watches the undervoltage and overvoltage comparator flags of three regulated output rails and two undervoltage flags of the input supply. Every flag passes through its own glitch filter, whose length is chosen from four settings counted in microsecond ticks. A flag that stays high for the whole filter window is treated as a real fault. Each channel exposes its filtered UV and OV state. It also has a sticky bit that software clears with a write-one-to-clear strobe.

Filtered faults drive three possible responses: a sequenced power-off request, an immediate force-shutdown request, and the open-drain supervisory pin. Rail faults and supply faults each have their own three-bit response mask. Manual mode suppresses both shutdown requests, but the pin still responds.

The pin has two modes. In health mode it tracks the live state of the enabled rails. In reset mode it holds the line low while the host reset input is high or a masked fault is present. After both clear, it releases once a programmable delay, counted in millisecond ticks, has elapsed.

Top module: `supply_fault_mon`

## Requirements
- R1: With a non-zero filter setting, a raw flag sets its filtered bit only after the flag has been high on that many consecutive cycles that carry a microsecond tick. The filter settings are: select 0 = 0, 1 = 8, 2 = 25, 3 = 50 ticks. A lower raw flag clears the filtered bit on the next clock edge and restarts the count. Cycles without a tick do not advance the count.
- R2: With filter select 0, a filtered bit follows its raw flag one clock later.
- R3: The channel status word gives three bits to channel i: bit 3i is the filtered UV flag, bit 3i+1 is the filtered OV flag, and bit 3i+2 is the sticky fault bit. The supply status output gives the filtered supply UV flags, one bit per flag.
- R4: The sticky bit of a channel is set by any filtered UV or OV fault on that channel while the channel is enabled. It stays set after the fault clears. It is cleared one clock after its strobe bit is high, unless a fault is present in that same cycle, in which case it stays set.
- R5: In health mode (pin mode 0), the pin drive output is 1 (line pulled low) while a filtered fault is present on an enabled channel and the rail mask pin bit is set. A disabled channel's faults are ignored.
- R6: Each of the two supply UV flags alone triggers the responses selected by the supply mask.
- R7: In reset mode (pin mode 1), the pin stays pulled low while a hold condition exists. After the hold clears, the pin releases once the programmed number of millisecond ticks has been counted. The delay settings are: select 0 = 50, 1 = 100, 2 = 200, 3 = 400 ticks. Cycles without a tick do not count.
- R8: In reset mode, a high host reset pulls the pin low at the next edge. In health mode, the host reset has no effect on the pin.
- R9: The response masks use bit 0 for power-off, bit 1 for force-shutdown and bit 2 for the pin. A request output is high only while a present fault's mask has that bit set.
- R10: While manual mode is high, the power-off and force-shutdown requests stay low. Status and pin behaviour are unchanged.
- R11: During reset, the pin drive is 1 and the requests and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond pulse |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| ch_uv_raw | input | NCH | Raw per-rail undervoltage flags |
| ch_ov_raw | input | NCH | Raw per-rail overvoltage flags |
| ch_en | input | NCH | Per-rail enabled status |
| sup_uv_raw | input | NSUP | Raw input-supply undervoltage flags |
| host_rst | input | 1 | Active-high host reset request |
| manual_mode | input | 1 | Suppresses shutdown requests |
| cfg_filt_sel | input | 2 | Glitch filter length select |
| cfg_rst_sel | input | 2 | Reset release delay select |
| cfg_pin_reset_mode | input | 1 | 0 = health indicator, 1 = delayed reset |
| cfg_ch_act | input | 3 | Response mask for rail faults |
| cfg_sup_act | input | 3 | Response mask for supply faults |
| sticky_clr | input | NCH | Write-one-to-clear strobe for sticky bits |
| ch_status | output | 3*NCH | Per-rail UV, OV and sticky bits |
| sup_status | output | NSUP | Filtered supply UV flags |
| poweroff_req | output | 1 | Sequenced power-off request |
| force_req | output | 1 | Immediate force-shutdown request |
| pin_pull_low | output | 1 | Open-drain drive, 1 pulls the line low |

## Verification
A filter counter that is stuck or miscounts shows up as a status bit rising one or more cycles before or after the programmed tick count. A missed clear leaves the bit high on the cycle after its raw flag drops. A wrong release counter in the pin driver moves the falling edge of the pin drive away from exactly the programmed number of millisecond ticks after the hold clears, so the offset is visible within that delay window. Wrong mask or manual gating shows as a request or pin value that differs from the expected one within two edges of a steady input pattern.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int unsigned FILT_US_S1 = 8;
    localparam int unsigned FILT_US_S2 = 25;
    localparam int unsigned FILT_US_S3 = 50;
    localparam int unsigned FILT_CW    = $clog2(FILT_US_S3 + 1);

    localparam int unsigned RST_MS_S0 = 50;
    localparam int unsigned RST_MS_S1 = 100;
    localparam int unsigned RST_MS_S2 = 200;
    localparam int unsigned RST_MS_S3 = 400;
    localparam int unsigned RST_CW    = $clog2(RST_MS_S3 + 1);

    typedef enum logic [1:0] {
        FILT_OFF   = 2'd0,
        FILT_SHORT = 2'd1,
        FILT_MID   = 2'd2,
        FILT_LONG  = 2'd3
    } filt_sel_e;

    typedef enum logic {
        PIN_HEALTH = 1'b0,
        PIN_RESET  = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic drive_pin;
        logic force_sd;
        logic power_off;
    } act_mask_t;

    function automatic logic [FILT_CW-1:0] filt_limit(input filt_sel_e sel);
        case (sel)
            FILT_SHORT: filt_limit = FILT_CW'(FILT_US_S1);
            FILT_MID:   filt_limit = FILT_CW'(FILT_US_S2);
            FILT_LONG:  filt_limit = FILT_CW'(FILT_US_S3);
            default:    filt_limit = '0;
        endcase
    endfunction

    function automatic logic [RST_CW-1:0] rst_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    rst_limit = RST_CW'(RST_MS_S0);
            2'd1:    rst_limit = RST_CW'(RST_MS_S1);
            2'd2:    rst_limit = RST_CW'(RST_MS_S2);
            default: rst_limit = RST_CW'(RST_MS_S3);
        endcase
    endfunction

endpackage

// File: rtl/sfm_glitch_filter.sv
module sfm_glitch_filter #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          flt
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            flt <= 1'b0;
        end else if (!raw) begin
            cnt <= '0;
            flt <= 1'b0;
        end else if (limit == '0) begin
            flt <= 1'b1;
        end else if (tick && !flt) begin
            if (cnt_nx >= limit) begin
                flt <= 1'b1;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/sfm_fault_resolver.sv
module sfm_fault_resolver
    import sfm_pkg::*;
#(
    parameter int unsigned NCH  = 3,
    parameter int unsigned NSUP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  ch_uv_f,
    input  logic [NCH-1:0]  ch_ov_f,
    input  logic [NSUP-1:0] sup_uv_f,
    input  logic [NCH-1:0]  ch_en,
    input  act_mask_t       ch_act,
    input  act_mask_t       sup_act,
    input  logic            manual_mode,
    input  logic [NCH-1:0]  sticky_clr,
    output logic [NCH-1:0]  sticky,
    output logic            poweroff_req,
    output logic            force_req,
    output logic            pin_fault
);

    logic [NCH-1:0] ch_bad;
    logic           ch_any;
    logic           sup_any;
    logic           poff_d;
    logic           force_d;

    always_comb begin
        ch_bad  = (ch_uv_f | ch_ov_f) & ch_en;
        ch_any  = |ch_bad;
        sup_any = |sup_uv_f;
        poff_d  = !manual_mode &&
                  ((ch_any && ch_act.power_off) || (sup_any && sup_act.power_off));
        force_d = !manual_mode &&
                  ((ch_any && ch_act.force_sd) || (sup_any && sup_act.force_sd));
        pin_fault = (ch_any && ch_act.drive_pin) || (sup_any && sup_act.drive_pin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            poweroff_req <= 1'b0;
            force_req    <= 1'b0;
        end else begin
            poweroff_req <= poff_d;
            force_req    <= force_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                sticky[i] <= 1'b0;
            end else if (ch_bad[i]) begin
                sticky[i] <= 1'b1;
            end else if (sticky_clr[i]) begin
                sticky[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfm_pin_driver.sv
module sfm_pin_driver
    import sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  pin_mode_e         mode,
    input  logic              host_rst,
    input  logic              pin_fault,
    input  logic [RST_CW-1:0] limit,
    output logic              pull_low
);

    logic [RST_CW-1:0] cnt;
    logic [RST_CW-1:0] cnt_nx;
    logic              hold;

    assign cnt_nx = cnt + 1'b1;
    assign hold   = pin_fault || host_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_low <= 1'b1;
            cnt      <= '0;
        end else if (mode == PIN_HEALTH) begin
            pull_low <= pin_fault;
            cnt      <= '0;
        end else if (hold) begin
            pull_low <= 1'b1;
            cnt      <= '0;
        end else if (pull_low && ms_tick) begin
            if (cnt_nx >= limit) begin
                pull_low <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/supply_fault_mon.sv
module supply_fault_mon
    import sfm_pkg::*;
#(
    parameter int unsigned NCH  = 3,
    parameter int unsigned NSUP = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               us_tick,
    input  logic               ms_tick,
    input  logic [NCH-1:0]     ch_uv_raw,
    input  logic [NCH-1:0]     ch_ov_raw,
    input  logic [NCH-1:0]     ch_en,
    input  logic [NSUP-1:0]    sup_uv_raw,
    input  logic               host_rst,
    input  logic               manual_mode,
    input  logic [1:0]         cfg_filt_sel,
    input  logic [1:0]         cfg_rst_sel,
    input  logic               cfg_pin_reset_mode,
    input  logic [2:0]         cfg_ch_act,
    input  logic [2:0]         cfg_sup_act,
    input  logic [NCH-1:0]     sticky_clr,
    output logic [3*NCH-1:0]   ch_status,
    output logic [NSUP-1:0]    sup_status,
    output logic               poweroff_req,
    output logic               force_req,
    output logic               pin_pull_low
);

    localparam int unsigned STW = 3;

    logic [FILT_CW-1:0] flim;
    logic [RST_CW-1:0]  rlim;
    logic [NCH-1:0]     uv_f;
    logic [NCH-1:0]     ov_f;
    logic [NSUP-1:0]    sup_f;
    logic [NCH-1:0]     sticky;
    logic               pin_fault;
    pin_mode_e          pmode;

    assign flim  = filt_limit(filt_sel_e'(cfg_filt_sel));
    assign rlim  = rst_limit(cfg_rst_sel);
    assign pmode = pin_mode_e'(cfg_pin_reset_mode);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sfm_glitch_filter #(.CW(FILT_CW)) u_uv (
            .clk(clk), .rst(rst), .tick(us_tick),
            .raw(ch_uv_raw[i]), .limit(flim), .flt(uv_f[i])
        );
        sfm_glitch_filter #(.CW(FILT_CW)) u_ov (
            .clk(clk), .rst(rst), .tick(us_tick),
            .raw(ch_ov_raw[i]), .limit(flim), .flt(ov_f[i])
        );
        assign ch_status[STW*i +: STW] = {sticky[i], ov_f[i], uv_f[i]};
    end

    for (genvar j = 0; j < NSUP; j++) begin : g_sup
        sfm_glitch_filter #(.CW(FILT_CW)) u_sup (
            .clk(clk), .rst(rst), .tick(us_tick),
            .raw(sup_uv_raw[j]), .limit(flim), .flt(sup_f[j])
        );
    end

    assign sup_status = sup_f;

    sfm_fault_resolver #(.NCH(NCH), .NSUP(NSUP)) u_res (
        .clk          (clk),
        .rst          (rst),
        .ch_uv_f      (uv_f),
        .ch_ov_f      (ov_f),
        .sup_uv_f     (sup_f),
        .ch_en        (ch_en),
        .ch_act       (act_mask_t'(cfg_ch_act)),
        .sup_act      (act_mask_t'(cfg_sup_act)),
        .manual_mode  (manual_mode),
        .sticky_clr   (sticky_clr),
        .sticky       (sticky),
        .poweroff_req (poweroff_req),
        .force_req    (force_req),
        .pin_fault    (pin_fault)
    );

    sfm_pin_driver u_pin (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .mode      (pmode),
        .host_rst  (host_rst),
        .pin_fault (pin_fault),
        .limit     (rlim),
        .pull_low  (pin_pull_low)
    );

endmodule

// File: rtl/supply_fault_mon_chk.sv
module supply_fault_mon_chk #(
    parameter int unsigned NCH  = 3,
    parameter int unsigned NSUP = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   ch_uv_raw,
    input logic [NCH-1:0]   sticky_clr,
    input logic [3*NCH-1:0] ch_status,
    input logic             host_rst,
    input logic             manual_mode,
    input logic             cfg_pin_reset_mode,
    input logic             poweroff_req,
    input logic             force_req,
    input logic             pin_pull_low
);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_UV_RISE_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_status[3*i]) |-> $past(ch_uv_raw[i])); // R1
        AST_UV_DROPS_WITH_RAW: assert property (@(posedge clk) disable iff (rst)
            $past(!ch_uv_raw[i]) |-> !ch_status[3*i]); // R1
        AST_STICKY_CLEAR_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
            $fell(ch_status[3*i+2]) |-> $past(sticky_clr[i])); // R4
    end

    AST_HOST_RESET_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(host_rst && cfg_pin_reset_mode) |-> pin_pull_low); // R8
    AST_RELEASE_AFTER_HOST_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($fell(pin_pull_low) && $past(cfg_pin_reset_mode)) |-> !$past(host_rst)); // R7
    AST_MANUAL_NO_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $past(manual_mode) |-> (!poweroff_req && !force_req)); // R10

endmodule

bind supply_fault_mon supply_fault_mon_chk #(.NCH(NCH), .NSUP(NSUP)) u_chk (
    .clk                (clk),
    .rst                (rst),
    .ch_uv_raw          (ch_uv_raw),
    .sticky_clr         (sticky_clr),
    .ch_status          (ch_status),
    .host_rst           (host_rst),
    .manual_mode        (manual_mode),
    .cfg_pin_reset_mode (cfg_pin_reset_mode),
    .poweroff_req       (poweroff_req),
    .force_req          (force_req),
    .pin_pull_low       (pin_pull_low)
);

// File: tb/sim_supply_fault_mon.sv
module sim_supply_fault_mon;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b1;
    logic       ms_tick = 1'b1;
    logic [2:0] ch_uv_raw = '0;
    logic [2:0] ch_ov_raw = '0;
    logic [2:0] ch_en = 3'b111;
    logic [1:0] sup_uv_raw = '0;
    logic       host_rst = 1'b0;
    logic       manual_mode = 1'b0;
    logic [1:0] cfg_filt_sel = 2'd0;
    logic [1:0] cfg_rst_sel = 2'd0;
    logic       cfg_pin_reset_mode = 1'b0;
    logic [2:0] cfg_ch_act = 3'b111;
    logic [2:0] cfg_sup_act = 3'b111;
    logic [2:0] sticky_clr = '0;
    logic [8:0] ch_status;
    logic [1:0] sup_status;
    logic       poweroff_req;
    logic       force_req;
    logic       pin_pull_low;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    supply_fault_mon u0 (
        .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick),
        .ch_uv_raw(ch_uv_raw), .ch_ov_raw(ch_ov_raw), .ch_en(ch_en),
        .sup_uv_raw(sup_uv_raw), .host_rst(host_rst), .manual_mode(manual_mode),
        .cfg_filt_sel(cfg_filt_sel), .cfg_rst_sel(cfg_rst_sel),
        .cfg_pin_reset_mode(cfg_pin_reset_mode), .cfg_ch_act(cfg_ch_act),
        .cfg_sup_act(cfg_sup_act), .sticky_clr(sticky_clr),
        .ch_status(ch_status), .sup_status(sup_status),
        .poweroff_req(poweroff_req), .force_req(force_req),
        .pin_pull_low(pin_pull_low)
    );

    // {uv, ov, en, sup, ch_act, sup_act, manual, exp_pin, exp_poff, exp_force}
    localparam logic [20:0] VEC [11] = '{
        21'b000_000_111_00_111_111_0_000,  // quiet
        21'b001_000_111_00_111_111_0_111,  // R5 enabled rail fault
        21'b001_000_110_00_111_111_0_000,  // R5 disabled rail ignored
        21'b000_100_111_00_001_000_0_010,  // R9 power-off only
        21'b000_010_111_00_010_000_0_001,  // R9 force only
        21'b000_010_111_00_100_000_0_100,  // R9 pin only
        21'b000_000_111_01_000_111_0_111,  // R6 supply flag 0
        21'b000_000_111_10_000_011_0_011,  // R6 supply flag 1
        21'b001_000_111_00_111_111_1_100,  // R10 manual
        21'b000_000_111_11_000_100_1_100,  // R10 manual, supply
        21'b010_001_111_00_000_000_0_000   // R9 empty masks
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] live_bits(input logic [2:0] uv, input logic [2:0] ov);
        logic [8:0] r = '0;
        for (int i = 0; i < 3; i++) begin
            r[3*i]   = uv[i];
            r[3*i+1] = ov[i];
        end
        return r;
    endfunction

    initial begin
        tick(3);
        chk("R11 pin", {31'd0, pin_pull_low}, 32'd1);
        chk("R11 req", {30'd0, poweroff_req, force_req}, 32'd0);
        chk("R11 status", {21'd0, ch_status, sup_status}, 32'd0);
        rst = 1'b0;

        // vector table: health mode, filter off
        for (int v = 0; v < 11; v++) begin
            {ch_uv_raw, ch_ov_raw, ch_en, sup_uv_raw, cfg_ch_act, cfg_sup_act,
             manual_mode} = VEC[v][20:3];
            tick(3);
            chk("R5/R6/R9/R10 pin", {31'd0, pin_pull_low}, {31'd0, VEC[v][2]});
            chk("R9/R10 poweroff", {31'd0, poweroff_req}, {31'd0, VEC[v][1]});
            chk("R9/R10 force", {31'd0, force_req}, {31'd0, VEC[v][0]});
            chk("R3 live bits", {23'd0, ch_status & 9'b011_011_011},
                {23'd0, live_bits(ch_uv_raw, ch_ov_raw)});
            chk("R3 supply bits", {30'd0, sup_status}, {30'd0, sup_uv_raw});
        end
        ch_uv_raw = '0; ch_ov_raw = '0; sup_uv_raw = '0; manual_mode = 1'b0;
        ch_en = 3'b111; cfg_ch_act = 3'b111; cfg_sup_act = 3'b111;
        tick(3);

        // R2: zero filter
        ch_ov_raw[2] = 1'b1;
        tick(1);
        chk("R2 set", {31'd0, ch_status[7]}, 32'd1);
        ch_ov_raw[2] = 1'b0;
        tick(1);
        chk("R2 clear", {31'd0, ch_status[7]}, 32'd0);

        // R1: 8-tick filter
        cfg_filt_sel = 2'd1;
        ch_uv_raw[1] = 1'b1;
        tick(7);
        chk("R1 short", {31'd0, ch_status[3]}, 32'd0);
        tick(1);
        chk("R1 full", {31'd0, ch_status[3]}, 32'd1);
        ch_uv_raw[1] = 1'b0;
        tick(1);
        chk("R1 drop", {31'd0, ch_status[3]}, 32'd0);
        ch_uv_raw[1] = 1'b1;
        tick(5);
        ch_uv_raw[1] = 1'b0;
        tick(1);
        ch_uv_raw[1] = 1'b1;
        tick(7);
        chk("R1 restart", {31'd0, ch_status[3]}, 32'd0);
        tick(1);
        chk("R1 restart full", {31'd0, ch_status[3]}, 32'd1);
        ch_uv_raw[1] = 1'b0;
        us_tick = 1'b0;
        tick(1);
        ch_uv_raw[1] = 1'b1;
        tick(20);
        chk("R1 no ticks", {31'd0, ch_status[3]}, 32'd0);
        ch_uv_raw[1] = 1'b0;
        us_tick = 1'b1;
        cfg_filt_sel = 2'd0;
        tick(2);

        // R4: sticky
        sticky_clr = 3'b111;
        tick(1);
        sticky_clr = '0;
        chk("R4 cleared", {29'd0, ch_status[8], ch_status[5], ch_status[2]}, 32'd0);
        ch_uv_raw[1] = 1'b1;
        tick(2);
        ch_uv_raw[1] = 1'b0;
        tick(3);
        chk("R4 held", {31'd0, ch_status[5]}, 32'd1);
        sticky_clr[1] = 1'b1;
        tick(1);
        sticky_clr[1] = 1'b0;
        chk("R4 strobe", {31'd0, ch_status[5]}, 32'd0);
        ch_uv_raw[2] = 1'b1;
        tick(2);
        sticky_clr[2] = 1'b1;
        tick(1);
        sticky_clr[2] = 1'b0;
        chk("R4 set wins", {31'd0, ch_status[8]}, 32'd1);
        ch_uv_raw[2] = 1'b0;
        ch_en[0] = 1'b0;
        ch_uv_raw[0] = 1'b1;
        tick(3);
        chk("R4 disabled", {31'd0, ch_status[2]}, 32'd0);
        ch_uv_raw[0] = 1'b0;
        ch_en[0] = 1'b1;
        tick(3);

        // R8: health mode ignores host reset
        host_rst = 1'b1;
        tick(3);
        chk("R8 health ignores", {31'd0, pin_pull_low}, 32'd0);
        host_rst = 1'b0;
        tick(1);

        // R7/R8: reset mode
        cfg_pin_reset_mode = 1'b1;
        cfg_rst_sel = 2'd0;
        tick(2);
        chk("R7 stays released", {31'd0, pin_pull_low}, 32'd0);
        host_rst = 1'b1;
        tick(1);
        chk("R8 assert", {31'd0, pin_pull_low}, 32'd1);
        host_rst = 1'b0;
        tick(49);
        chk("R7 50 early", {31'd0, pin_pull_low}, 32'd1);
        tick(1);
        chk("R7 50 release", {31'd0, pin_pull_low}, 32'd0);

        cfg_rst_sel = 2'd3;
        host_rst = 1'b1;
        tick(2);
        host_rst = 1'b0;
        tick(399);
        chk("R7 400 early", {31'd0, pin_pull_low}, 32'd1);
        tick(1);
        chk("R7 400 release", {31'd0, pin_pull_low}, 32'd0);

        cfg_rst_sel = 2'd1;
        ch_uv_raw[0] = 1'b1;
        tick(3);
        chk("R7 fault hold", {31'd0, pin_pull_low}, 32'd1);
        ch_uv_raw[0] = 1'b0;
        tick(100);
        chk("R7 100 early", {31'd0, pin_pull_low}, 32'd1);
        tick(1);
        chk("R7 100 release", {31'd0, pin_pull_low}, 32'd0);

        host_rst = 1'b1;
        tick(1);
        host_rst = 1'b0;
        ms_tick = 1'b0;
        tick(60);
        chk("R7 no ms ticks", {31'd0, pin_pull_low}, 32'd1);
        ms_tick = 1'b1;
        tick(99);
        chk("R7 gated early", {31'd0, pin_pull_low}, 32'd1);
        tick(1);
        chk("R7 gated release", {31'd0, pin_pull_low}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule